// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block resolves control flow for a 32-bit core with word-aligned instructions. Each cycle it may be handed the fetch PC, the instruction word and the two operand values that the register file read for the instruction's two source fields. It returns the PC to fetch next, a flag saying whether control flow left the sequential path, a link-register write with its value, and a code saying what kind of return a register branch performed. The register file and the interrupt-enable bookkeeping sit outside. A control-register block consumes the return code and restores its enables.

The instruction word carries the opcode in bits [31:26], the first source register field in bits [25:21] (its value arrives on `in_opa`), the second source field in bits [20:16] (value on `in_opb`), a 16-bit offset in bits [15:0] and a 26-bit offset in bits [25:0]. The outputs are registered by default, so results appear one clock after the instruction is presented. With `OUT_STAGE` set to 0 the block is purely combinational.

Top module: `bnpc_unit`

## Requirements
- R1: While reset is asserted and on the first sampling after it, every output is zero.
- R2: `out_valid` follows `in_valid` one cycle later; in a cycle with `out_valid` low, `out_next_pc`, `out_taken`, `out_link_we`, `out_link_val` and `out_ret_kind` are all zero.
- R3: Opcodes 0x11 (equal), 0x17 (not equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x15 (unsigned greater) and 0x14 (unsigned greater-or-equal) compare `in_opa` against `in_opb`. When the condition holds, `out_taken` is 1 and the next PC is the aligned PC plus the sign-extended bits [15:0] times 4.
- R4: A conditional branch whose condition fails gives the aligned PC plus 4 with `out_taken` 0.
- R5: Opcode 0x38 jumps to the aligned PC plus the sign-extended bits [25:0] times 4, with `out_taken` 1 and no link write.
- R6: Opcode 0x3E (call to PC-relative target, computed as in R5) and opcode 0x36 (call to `in_opa`) both assert `out_taken` and `out_link_we`, with `out_link_val` equal to the aligned PC plus 4. The link destination is the fixed register `LINK_REG` (29).
- R7: Opcode 0x30 jumps to `in_opa` with `out_taken` 1. `out_ret_kind` encodes the register field in bits [25:21]: 29 gives 1 (subroutine return), 30 gives 2 (exception return), 31 gives 3 (debug return), and any other register gives 0. `out_ret_kind` is 0 for every other opcode.
- R8: Bits [1:0] of `in_pc` have no effect, and bits [1:0] of `out_next_pc` are always 0, including for register targets.
- R9: Any other opcode gives the aligned PC plus 4, with `out_taken` and `out_link_we` both 0. All PC arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | 32 | Fetch PC of the instruction |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 32 | Value of the register named by bits [25:21] |
| in_opb | input | 32 | Value of the register named by bits [20:16] |
| out_valid | output | 1 | Results below belong to an instruction |
| out_next_pc | output | 32 | PC to fetch next |
| out_taken | output | 1 | Control flow left the sequential path |
| out_link_we | output | 1 | Write `out_link_val` into the link register |
| out_link_val | output | 32 | Return address for calls |
| out_ret_kind | output | 2 | 0 none, 1 subroutine, 2 exception, 3 debug return |

## Verification
With the default output stage, every result for an instruction is due exactly one clock after the edge that captures it: the next PC, the taken flag, the link write and the return code all land together, and an idle cycle yields zeros one clock later. The bench drives each vector on a falling edge and lets one rising edge pass. On the following falling edge it compares all outputs against the model's prediction for that vector, and then drives the next vector. The vectors walk signed versus unsigned comparison boundaries, negative offsets, misaligned PCs and register targets, each return register, PC wraparound and a random mix.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

   localparam int INSTR_W  = 32;
   localparam int OPC_MSB  = 31;
   localparam int OPC_LSB  = 26;
   localparam int OPC_W    = OPC_MSB - OPC_LSB + 1;
   localparam int RSA_MSB  = 25;
   localparam int RSA_LSB  = 21;
   localparam int RIDX_W   = RSA_MSB - RSA_LSB + 1;
   localparam int OFS_S_W  = 16;
   localparam int OFS_L_W  = 26;
   localparam int WORD_SH  = 2;

   // opcode values are decoded by the fetch path and the compiler alike
   localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'h11;
   localparam logic [OPC_W-1:0] OPC_BR_GTS  = 6'h12;
   localparam logic [OPC_W-1:0] OPC_BR_GES  = 6'h13;
   localparam logic [OPC_W-1:0] OPC_BR_GEU  = 6'h14;
   localparam logic [OPC_W-1:0] OPC_BR_GTU  = 6'h15;
   localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'h17;
   localparam logic [OPC_W-1:0] OPC_JMP_REG = 6'h30;
   localparam logic [OPC_W-1:0] OPC_CALL_RG = 6'h36;
   localparam logic [OPC_W-1:0] OPC_JMP_IMM = 6'h38;
   localparam logic [OPC_W-1:0] OPC_CALL_IM = 6'h3E;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_NE  = 3'd1,
      CMP_GTS = 3'd2,
      CMP_GES = 3'd3,
      CMP_GTU = 3'd4,
      CMP_GEU = 3'd5
   } cmp_op_e;

   typedef enum logic [1:0] {
      RET_NONE = 2'd0,
      RET_SUB  = 2'd1,
      RET_EXC  = 2'd2,
      RET_DBG  = 2'd3
   } ret_kind_e;

   typedef struct packed {
      logic    is_cond;
      logic    is_jimm;
      logic    is_jreg;
      logic    is_cimm;
      logic    is_creg;
      cmp_op_e cmp;
   } br_class_t;

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
   import bnpc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output br_class_t        cls
);

   always_comb begin
      cls         = '0;
      cls.cmp     = CMP_EQ;
      unique case (opcode)
         OPC_BR_EQ:   begin cls.is_cond = 1'b1; cls.cmp = CMP_EQ;  end
         OPC_BR_NE:   begin cls.is_cond = 1'b1; cls.cmp = CMP_NE;  end
         OPC_BR_GTS:  begin cls.is_cond = 1'b1; cls.cmp = CMP_GTS; end
         OPC_BR_GES:  begin cls.is_cond = 1'b1; cls.cmp = CMP_GES; end
         OPC_BR_GTU:  begin cls.is_cond = 1'b1; cls.cmp = CMP_GTU; end
         OPC_BR_GEU:  begin cls.is_cond = 1'b1; cls.cmp = CMP_GEU; end
         OPC_JMP_IMM: cls.is_jimm = 1'b1;
         OPC_JMP_REG: cls.is_jreg = 1'b1;
         OPC_CALL_IM: cls.is_cimm = 1'b1;
         OPC_CALL_RG: cls.is_creg = 1'b1;
         default:     cls.is_cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/bnpc_cmp.sv
module bnpc_cmp
   import bnpc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  cmp_op_e      op,
   output logic         hit
);

   logic eq_w, gts_w, gtu_w;

   assign eq_w  = (lhs == rhs);
   assign gts_w = ($signed(lhs) > $signed(rhs));
   assign gtu_w = (lhs > rhs);

   always_comb begin
      unique case (op)
         CMP_EQ:  hit = eq_w;
         CMP_NE:  hit = !eq_w;
         CMP_GTS: hit = gts_w;
         CMP_GES: hit = gts_w || eq_w;
         CMP_GTU: hit = gtu_w;
         CMP_GEU: hit = gtu_w || eq_w;
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
   import bnpc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0]       pc,
   input  logic [INSTR_W-1:0] instr,
   input  logic [W-1:0]       reg_tgt,
   input  br_class_t          cls,
   input  logic               cond_hit,
   output logic [W-1:0]       next_pc,
   output logic [W-1:0]       seq_pc,
   output logic               taken
);

   localparam int SHW = OFS_S_W + WORD_SH;
   localparam int LNW = OFS_L_W + WORD_SH;

   logic [W-1:0] base;
   logic [W-1:0] ofs_short;
   logic [W-1:0] ofs_long;
   logic [W-1:0] rel_short;
   logic [W-1:0] rel_long;
   logic [W-1:0] raw;

   assign base      = {pc[W-1:WORD_SH], {WORD_SH{1'b0}}};
   assign ofs_short = {{(W-SHW){instr[OFS_S_W-1]}}, instr[OFS_S_W-1:0], {WORD_SH{1'b0}}};
   assign ofs_long  = {{(W-LNW){instr[OFS_L_W-1]}}, instr[OFS_L_W-1:0], {WORD_SH{1'b0}}};
   assign seq_pc    = base + W'(4);
   assign rel_short = base + ofs_short;
   assign rel_long  = base + ofs_long;

   always_comb begin
      taken = 1'b1;
      raw   = seq_pc;
      if (cls.is_cond) begin
         taken = cond_hit;
         raw   = cond_hit ? rel_short : seq_pc;
      end else if (cls.is_jimm || cls.is_cimm) begin
         raw = rel_long;
      end else if (cls.is_jreg || cls.is_creg) begin
         raw = reg_tgt;
      end else begin
         taken = 1'b0;
      end
   end

   assign next_pc = {raw[W-1:WORD_SH], {WORD_SH{1'b0}}};

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
   import bnpc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit OUT_STAGE = 1'b1,
   parameter int LINK_REG  = 29,
   parameter int EXC_REG   = 30,
   parameter int DBG_REG   = 31
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] in_pc,
   input  logic [31:0]     in_instr,
   input  logic [XLEN-1:0] in_opa,
   input  logic [XLEN-1:0] in_opb,
   output logic            out_valid,
   output logic [XLEN-1:0] out_next_pc,
   output logic            out_taken,
   output logic            out_link_we,
   output logic [XLEN-1:0] out_link_val,
   output logic [1:0]      out_ret_kind
);

   localparam int REG_CNT = 1 << RIDX_W;

   if (XLEN < INSTR_W) begin : g_bad_xlen
      $error("bnpc_unit: XLEN must hold a full instruction offset");
   end
   if (LINK_REG >= REG_CNT || EXC_REG >= REG_CNT || DBG_REG >= REG_CNT) begin : g_bad_reg
      $error("bnpc_unit: special register index out of range");
   end
   if (LINK_REG == EXC_REG || LINK_REG == DBG_REG || EXC_REG == DBG_REG) begin : g_dup_reg
      $error("bnpc_unit: special registers must differ");
   end

   br_class_t       cls;
   logic            cond_hit;
   logic [XLEN-1:0] c_next;
   logic [XLEN-1:0] c_seq;
   logic            c_taken;
   logic            c_link;
   ret_kind_e       c_ret;
   logic [RIDX_W-1:0] rsel;

   bnpc_decode u_dec (
      .opcode (in_instr[OPC_MSB:OPC_LSB]),
      .cls    (cls)
   );

   bnpc_cmp #(.W(XLEN)) u_cmp (
      .lhs (in_opa),
      .rhs (in_opb),
      .op  (cls.cmp),
      .hit (cond_hit)
   );

   bnpc_target #(.W(XLEN)) u_tgt (
      .pc       (in_pc),
      .instr    (in_instr),
      .reg_tgt  (in_opa),
      .cls      (cls),
      .cond_hit (cond_hit),
      .next_pc  (c_next),
      .seq_pc   (c_seq),
      .taken    (c_taken)
   );

   assign rsel   = in_instr[RSA_MSB:RSA_LSB];
   assign c_link = cls.is_cimm || cls.is_creg;

   always_comb begin
      c_ret = RET_NONE;
      if (cls.is_jreg) begin
         if (rsel == RIDX_W'(LINK_REG))     c_ret = RET_SUB;
         else if (rsel == RIDX_W'(EXC_REG)) c_ret = RET_EXC;
         else if (rsel == RIDX_W'(DBG_REG)) c_ret = RET_DBG;
      end
   end

   if (OUT_STAGE) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            out_next_pc  <= '0;
            out_taken    <= 1'b0;
            out_link_we  <= 1'b0;
            out_link_val <= '0;
            out_ret_kind <= 2'd0;
         end else begin
            out_valid    <= in_valid;
            out_next_pc  <= in_valid ? c_next : '0;
            out_taken    <= in_valid && c_taken;
            out_link_we  <= in_valid && c_link;
            out_link_val <= (in_valid && c_link) ? c_seq : '0;
            out_ret_kind <= in_valid ? c_ret : 2'd0;
         end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R2
      AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !c_taken) |=>
            out_next_pc == ({$past(in_pc[XLEN-1:2]), 2'b00} + XLEN'(4))); // R4
      AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (cls.is_cimm || cls.is_creg)) |=>
            (out_link_we && out_link_val == ({$past(in_pc[XLEN-1:2]), 2'b00} + XLEN'(4)))); // R6
      AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cls.is_jreg) |=>
            (out_taken && out_next_pc == {$past(in_opa[XLEN-1:2]), 2'b00})); // R7
   end else begin : g_comb
      assign out_valid    = in_valid;
      assign out_next_pc  = in_valid ? c_next : '0;
      assign out_taken    = in_valid && c_taken;
      assign out_link_we  = in_valid && c_link;
      assign out_link_val = (in_valid && c_link) ? c_seq : '0;
      assign out_ret_kind = in_valid ? c_ret : 2'd0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_taken && !out_link_we && out_ret_kind == 2'd0)); // R2
   AST_LINK_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      out_link_we |-> out_taken); // R6
   AST_RET_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ret_kind != 2'd0) |-> out_taken); // R7
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_next_pc[1:0] == 2'b00); // R8
   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cls.is_cond, cls.is_jimm, cls.is_jreg, cls.is_cimm, cls.is_creg})); // R9

endmodule

// File: tb/bnpc_unit_test.sv
module bnpc_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_pc = '0;
   logic [31:0] in_instr = '0;
   logic [31:0] in_opa = '0;
   logic [31:0] in_opb = '0;
   logic        out_valid;
   logic [31:0] out_next_pc;
   logic        out_taken;
   logic        out_link_we;
   logic [31:0] out_link_val;
   logic [1:0]  out_ret_kind;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   bnpc_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
      .in_instr(in_instr), .in_opa(in_opa), .in_opb(in_opb),
      .out_valid(out_valid), .out_next_pc(out_next_pc), .out_taken(out_taken),
      .out_link_we(out_link_we), .out_link_val(out_link_val),
      .out_ret_kind(out_ret_kind)
   );

   // expected result of the vector driven one cycle earlier
   logic        e_v, e_t, e_l;
   logic [31:0] e_pc, e_lv;
   logic [1:0]  e_rk;
   string       e_tag;
   bit          have_exp = 0;

   function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int imm);
      logic [31:0] w;
      w = {op[5:0], ra[4:0], rb[4:0], imm[15:0]};
      return w;
   endfunction

   task automatic model(input logic v, input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
      int op;
      longint unsigned base, tgt;
      longint s16, s26;
      bit take;
      bit is_b;
      op   = int'(ins[31:26]);
      base = longint'(pc) & 64'hFFFF_FFFC;
      s16  = longint'($signed(ins[15:0])) * 4;
      s26  = longint'($signed({ins[25:0], 6'b0})) / 64 * 4;
      e_v = v; e_t = 0; e_l = 0; e_lv = 0; e_rk = 0; e_pc = 0;
      if (!v) begin e_tag = "R2"; return; end
      tgt = base + 4; is_b = 1; take = 0;
      case (op)
         'h11: take = (a == b);
         'h17: take = (a != b);
         'h12: take = ($signed(a) > $signed(b));
         'h13: take = ($signed(a) >= $signed(b));
         'h15: take = (a > b);
         'h14: take = (a >= b);
         default: is_b = 0;
      endcase
      if (is_b) begin
         e_tag = take ? "R3" : "R4";
         if (take) tgt = base + longint'(s16);
         e_t = take;
      end else if (op == 'h38) begin
         e_tag = "R5"; e_t = 1; tgt = base + longint'(s26);
      end else if (op == 'h3E || op == 'h36) begin
         e_tag = "R6"; e_t = 1; e_l = 1; e_lv = 32'(base + 4);
         tgt = (op == 'h3E) ? base + longint'(s26) : longint'(a);
      end else if (op == 'h30) begin
         e_tag = "R7"; e_t = 1; tgt = longint'(a);
         case (int'(ins[25:21]))
            29: e_rk = 1;
            30: e_rk = 2;
            31: e_rk = 3;
            default: e_rk = 0;
         endcase
      end else begin
         e_tag = "R9";
      end
      e_pc = 32'(tgt) & 32'hFFFF_FFFC;   // R8
   endtask

   task automatic check_now();
      tests++;
      if (out_valid !== e_v || out_next_pc !== e_pc || out_taken !== e_t ||
          out_link_we !== e_l || out_link_val !== e_lv || out_ret_kind !== e_rk) begin
         fails++;
         $display("FAIL %s: got v=%0b pc=%08h t=%0b l=%0b lv=%08h rk=%0d exp v=%0b pc=%08h t=%0b l=%0b lv=%08h rk=%0d",
                  e_tag, out_valid, out_next_pc, out_taken, out_link_we, out_link_val, out_ret_kind,
                  e_v, e_pc, e_t, e_l, e_lv, e_rk);
      end
   endtask

   // one step: check previous vector's result, then drive a new one
   task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      if (have_exp) check_now();
      in_valid = v; in_pc = pc; in_instr = ins; in_opa = a; in_opb = b;
      model(v, pc, ins, a, b);
      have_exp = 1;
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      int ops[10];
      ops = '{'h11, 'h17, 'h12, 'h13, 'h15, 'h14, 'h38, 'h3E, 'h36, 'h30};
      repeat (3) @(negedge clk);
      // R1: reset state
      e_v = 0; e_pc = 0; e_t = 0; e_l = 0; e_lv = 0; e_rk = 0; e_tag = "R1";
      check_now();
      @(negedge clk);
      rst_n = 1'b1;
      e_tag = "R1";
      check_now();

      step(1, 32'h0000_1000, mk('h11, 1, 2, 16'h0010), 32'd7, 32'd7);          // R3 eq taken
      step(1, 32'h0000_1000, mk('h11, 1, 2, 16'h0010), 32'd7, 32'd8);          // R4 eq not taken
      step(1, 32'h0000_2000, mk('h17, 1, 2, 16'hFFF0), 32'd1, 32'd2);          // R3 ne, negative offset
      step(1, 32'h0000_3000, mk('h12, 1, 2, 16'h0004), 32'hFFFF_FFFF, 32'd1);  // R4 signed gt fails
      step(1, 32'h0000_3000, mk('h15, 1, 2, 16'h0004), 32'hFFFF_FFFF, 32'd1);  // R3 unsigned gt holds
      step(1, 32'h0000_3000, mk('h13, 1, 2, 16'h0008), 32'h8000_0000, 32'h8000_0000); // R3 ge equal
      step(1, 32'h0000_3000, mk('h14, 1, 2, 16'h0008), 32'd3, 32'd4);          // R4 geu fails
      step(1, 32'h0000_4000, {6'h38, 26'h3FF_FFFF}, 32'd0, 32'd0);              // R5 back by 4
      step(1, 32'h0000_4000, {6'h38, 26'h200_0000}, 32'd0, 32'd0);              // R5 most negative
      step(1, 32'h0000_5000, {6'h3E, 26'h000_0100}, 32'd0, 32'd0);              // R6 immediate call
      step(1, 32'h0000_5004, mk('h36, 4, 0, 0), 32'h0000_9000, 32'd0);         // R6 register call
      step(1, 32'h0000_6000, mk('h30, 29, 0, 0), 32'h0000_5008, 32'd0);        // R7 return
      step(1, 32'h0000_6000, mk('h30, 30, 0, 0), 32'h0000_0200, 32'd0);        // R7 exception return
      step(1, 32'h0000_6000, mk('h30, 31, 0, 0), 32'h0000_0300, 32'd0);        // R7 debug return
      step(1, 32'h0000_6000, mk('h30, 5, 0, 0), 32'h0000_0400, 32'd0);         // R7 plain
      step(1, 32'h0000_7003, mk('h11, 1, 2, 16'h0001), 32'd0, 32'd0);          // R8 misaligned pc
      step(1, 32'h0000_7000, mk('h30, 7, 0, 0), 32'h0000_8003, 32'd0);         // R8 misaligned target
      step(1, 32'h0000_7000, mk('h0D, 1, 2, 16'h1234), 32'd1, 32'd1);          // R9 non-branch
      step(1, 32'hFFFF_FFFC, mk('h00, 0, 0, 0), 32'd0, 32'd0);                 // R9 wraparound
      step(0, 32'h0000_1000, mk('h38, 0, 0, 16'h0040), 32'd0, 32'd0);          // R2 idle
      step(1, 32'h0000_1000, mk('h36, 29, 0, 0), 32'h0000_0040, 32'd0);        // R6 ret kind stays 0

      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         int sel;
         sel = int'($urandom_range(0, 11));
         w = $urandom;
         if (sel < 10) w[31:26] = 6'(ops[sel]);
         if (sel == 9 && w[0]) w[25:21] = 5'(29 + int'($urandom_range(0, 2)));
         step(($urandom_range(0, 7) != 0), $urandom, w,
              (w[1] ? $urandom : 32'h0000_0010), (w[2] ? $urandom : 32'h0000_0010));
      end
      step(0, 0, 0, 0, 0);
      @(negedge clk);
      check_now();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule